// File: doc/BRIEF.md
# Vector SHA-2 Sigma Unit

This unit evaluates the SHA-2 sigma functions on every lane of a 128-bit operand in a single step. A mode input chooses between four 32-bit lanes, for the SHA-256 functions, and two 64-bit lanes, for the SHA-512 functions. A type select chooses between the two families. One family is the message-expansion sigmas, which end with a logical shift. The other is the compression sigmas, which are made of three rotations only. A 4-bit lane mask then picks, for each lane, the first or the second function of the chosen family.

A caller presents the operand, mode, type select and mask together with a valid strobe. The result appears in an output register on the next clock edge, flagged by an output valid bit. Lanes are counted from the most significant end of the vector. Lane masks are read from the most significant mask bit downward. In 64-bit mode only mask bits 3 and 1 are consulted.

Top module: `sha2_sigma_vec`

## Requirements
- R1: With modeDword=0 and bigSel=0, each 32-bit lane x gives rotr(x,7)^rotr(x,18)^(x>>3) when its mask bit is 0, and rotr(x,17)^rotr(x,19)^(x>>10) when it is 1. Shifts are logical, and rotations wrap within the lane.
- R2: With modeDword=0 and bigSel=1, each 32-bit lane gives rotr(x,2)^rotr(x,13)^rotr(x,22) when its mask bit is 0, and rotr(x,6)^rotr(x,11)^rotr(x,25) when it is 1.
- R3: With modeDword=1 and bigSel=0, each 64-bit lane gives rotr(x,1)^rotr(x,8)^(x>>7) when its mask bit is 0, and rotr(x,19)^rotr(x,61)^(x>>6) when it is 1.
- R4: With modeDword=1 and bigSel=1, each 64-bit lane gives rotr(x,28)^rotr(x,34)^rotr(x,39) when its mask bit is 0, and rotr(x,14)^rotr(x,18)^rotr(x,41) when it is 1.
- R5: In 32-bit mode, lane i (i=0..3) occupies bits [127-32i -: 32] and is controlled by laneMask[3-i].
- R6: In 64-bit mode, lane 0 (bits 127:64) is controlled by laneMask[3] and lane 1 (bits 63:0) by laneMask[1]. laneMask[2] and laneMask[0] have no effect on the result.
- R7: outValid is 1 in the cycle after inValid is 1, and 0 in the cycle after inValid is 0. The result register loads on the same edge.
- R8: When inValid is 0, the result register keeps its previous value.
- R9: A synchronous active-high rst clears result to zero and outValid to 0.
- R10: An all-zero operand yields an all-zero result in every configuration. An all-ones operand with bigSel=1 yields an all-ones result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operand and controls are valid this cycle |
| modeDword | input | 1 | 0: four 32-bit lanes, 1: two 64-bit lanes |
| bigSel | input | 1 | 0: message-expansion sigmas, 1: compression sigmas |
| laneMask | input | 4 | Per-lane function pick, MSB controls lane 0 |
| opA | input | 128 | Operand vector, lane 0 in the top bits |
| outValid | output | 1 | Result register was loaded on the last edge |
| result | output | 128 | Registered sigma results |

## Verification
The assertions assume that rst is asserted before the first clock edge, and that inValid is a clean 0 or 1 on every edge after that. This keeps the hold and timing properties meaningful from the first cycle. The zero and all-ones properties rely only on the operand value, so the stimulus drives both patterns in every mode, select and mask combination. The bench changes inputs only on falling edges, which keeps them stable around each rising edge. Between applied vectors it drops inValid for a cycle, so the hold behaviour is exercised throughout.

// File: rtl/sha2_sigma_pkg.sv
package sha2_sigma_pkg;

  localparam int VEC_W    = 128;
  localparam int WORD_W   = 32;
  localparam int DWORD_W  = 64;
  localparam int N_WORDS  = VEC_W / WORD_W;
  localparam int N_DWORDS = VEC_W / DWORD_W;
  localparam int MASK_W   = 4;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic              load;
    logic              dwMode;
    logic              bigSel;
    logic [N_WORDS-1:0] laneFn;  // laneFn[i] is the pick for lane i (lane 0 = top)
  } sigmaCtl_t;

  function automatic logic [WORD_W-1:0] rotr32(input logic [WORD_W-1:0] x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic logic [DWORD_W-1:0] rotr64(input logic [DWORD_W-1:0] x, input int n);
    return (x >> n) | (x << (DWORD_W - n));
  endfunction

  function automatic logic [WORD_W-1:0] sigma32(input logic [WORD_W-1:0] x,
                                                input logic big, input logic fn);
    logic [WORD_W-1:0] r;
    case ({big, fn})
      2'b00:   r = rotr32(x, 7)  ^ rotr32(x, 18) ^ (x >> 3);
      2'b01:   r = rotr32(x, 17) ^ rotr32(x, 19) ^ (x >> 10);
      2'b10:   r = rotr32(x, 2)  ^ rotr32(x, 13) ^ rotr32(x, 22);
      default: r = rotr32(x, 6)  ^ rotr32(x, 11) ^ rotr32(x, 25);
    endcase
    return r;
  endfunction

  function automatic logic [DWORD_W-1:0] sigma64(input logic [DWORD_W-1:0] x,
                                                 input logic big, input logic fn);
    logic [DWORD_W-1:0] r;
    case ({big, fn})
      2'b00:   r = rotr64(x, 1)  ^ rotr64(x, 8)  ^ (x >> 7);
      2'b01:   r = rotr64(x, 19) ^ rotr64(x, 61) ^ (x >> 6);
      2'b10:   r = rotr64(x, 28) ^ rotr64(x, 34) ^ rotr64(x, 39);
      default: r = rotr64(x, 14) ^ rotr64(x, 18) ^ rotr64(x, 41);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sigma_ctrl.sv
module sigma_ctrl
  import sha2_sigma_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              modeDword,
  input  logic              bigSel,
  input  logic [MASK_W-1:0] laneMask,
  output sigmaCtl_t         ctl,
  output logic              outValid
);

  localparam int DW_STRIDE = N_WORDS / N_DWORDS;  // mask stride in 64-bit mode

  logic [N_WORDS-1:0] fnWord;
  logic [N_WORDS-1:0] fnDword;

  for (genvar i = 0; i < N_WORDS; i++) begin : g_wsel
    assign fnWord[i] = laneMask[MASK_W-1-i];
  end

  for (genvar i = 0; i < N_WORDS; i++) begin : g_dsel
    if (i < N_DWORDS) begin : g_used
      assign fnDword[i] = laneMask[MASK_W-1-DW_STRIDE*i];
    end else begin : g_unused
      assign fnDword[i] = 1'b0;
    end
  end

  always_comb begin
    ctl.load   = inValid;
    ctl.dwMode = modeDword;
    ctl.bigSel = bigSel;
    ctl.laneFn = modeDword ? fnDword : fnWord;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R7: valid output trails the input strobe by exactly one edge
  p_valid_follow_r7: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  p_valid_drop_r7: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

endmodule

// File: rtl/sigma_datapath.sv
module sigma_datapath
  import sha2_sigma_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  sigmaCtl_t        ctl,
  input  logic [VEC_W-1:0] opA,
  output logic [VEC_W-1:0] result
);

  logic [VEC_W-1:0] wordVec;
  logic [VEC_W-1:0] dwordVec;
  logic [VEC_W-1:0] nextVec;

  for (genvar i = 0; i < N_WORDS; i++) begin : g_word
    localparam int HI = VEC_W - 1 - i * WORD_W;
    assign wordVec[HI -: WORD_W] = sigma32(opA[HI -: WORD_W], ctl.bigSel, ctl.laneFn[i]);
  end

  for (genvar i = 0; i < N_DWORDS; i++) begin : g_dword
    localparam int HI = VEC_W - 1 - i * DWORD_W;
    assign dwordVec[HI -: DWORD_W] = sigma64(opA[HI -: DWORD_W], ctl.bigSel, ctl.laneFn[i]);
  end

  assign nextVec = ctl.dwMode ? dwordVec : wordVec;

  always_ff @(posedge clk) begin
    if (rst)           result <= '0;
    else if (ctl.load) result <= nextVec;
  end

  // R8: register holds when nothing is loaded
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !ctl.load |=> $stable(result));
  // R10: zero operand maps to zero in every configuration
  p_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (ctl.load && opA == '0) |=> (result == '0));
  // R10: three-rotation functions map all ones to all ones
  p_ones_r10: assert property (@(posedge clk) disable iff (rst)
    (ctl.load && ctl.bigSel && opA == '1) |=> (result == '1));

endmodule

// File: rtl/sha2_sigma_vec.sv
module sha2_sigma_vec
  import sha2_sigma_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic         modeDword,
  input  logic         bigSel,
  input  logic [3:0]   laneMask,
  input  logic [127:0] opA,
  output logic         outValid,
  output logic [127:0] result
);

  sigmaCtl_t ctl;

  sigma_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .modeDword(modeDword),
    .bigSel   (bigSel),
    .laneMask (laneMask),
    .ctl      (ctl),
    .outValid (outValid)
  );

  sigma_datapath u_dp (
    .clk   (clk),
    .rst   (rst),
    .ctl   (ctl),
    .opA   (opA),
    .result(result)
  );

endmodule

// File: tb/tb_sha2_sigma_vec.sv
module tb_sha2_sigma_vec;

  localparam int CLK_PERIOD = 10;
  localparam int N_OPS = 6;
  localparam logic [127:0] OPS [N_OPS] = '{
    128'h0,
    {128{1'b1}},
    128'h1,
    {1'b1, 127'b0},
    128'h0123456789abcdef_fedcba9876543210,
    128'hdeadbeef_c0ffee00_5a5aa5a5_80000001
  };

  logic         clk = 1'b0;
  logic         rst;
  logic         inValid;
  logic         modeDword;
  logic         bigSel;
  logic [3:0]   laneMask;
  logic [127:0] opA;
  logic         outValid;
  logic [127:0] result;

  int nTests = 0;
  int nFail  = 0;

  sha2_sigma_vec dut (
    .clk(clk), .rst(rst), .inValid(inValid), .modeDword(modeDword),
    .bigSel(bigSel), .laneMask(laneMask), .opA(opA),
    .outValid(outValid), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] rr32(logic [31:0] x, int n);
    logic [63:0] d = {x, x};
    return d[n +: 32];
  endfunction

  function automatic logic [63:0] rr64(logic [63:0] x, int n);
    logic [127:0] d = {x, x};
    return d[n +: 64];
  endfunction

  function automatic logic [127:0] model(logic [127:0] x, logic dw, logic big, logic [3:0] m);
    logic [127:0] r = '0;
    if (!dw) begin
      for (int i = 0; i < 4; i++) begin
        logic [31:0] w = x[127-32*i -: 32];
        logic [31:0] y;
        if (!big) y = m[3-i] ? (rr32(w,17) ^ rr32(w,19) ^ (w >> 10)) : (rr32(w,7) ^ rr32(w,18) ^ (w >> 3));
        else      y = m[3-i] ? (rr32(w,6) ^ rr32(w,11) ^ rr32(w,25)) : (rr32(w,2) ^ rr32(w,13) ^ rr32(w,22));
        r[127-32*i -: 32] = y;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        logic [63:0] w = x[127-64*i -: 64];
        logic [63:0] y;
        logic b = m[3-2*i];
        if (!big) y = b ? (rr64(w,19) ^ rr64(w,61) ^ (w >> 6)) : (rr64(w,1) ^ rr64(w,8) ^ (w >> 7));
        else      y = b ? (rr64(w,14) ^ rr64(w,18) ^ rr64(w,41)) : (rr64(w,28) ^ rr64(w,34) ^ rr64(w,39));
        r[127-64*i -: 64] = y;
      end
    end
    return r;
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Present one vector for one cycle; on return the output of that edge is visible
  task automatic apply(logic [127:0] x, logic dw, logic big, logic [3:0] m);
    @(negedge clk);
    opA = x; modeDword = dw; bigSel = big; laneMask = m; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [127:0] held;
    rst = 1'b1; inValid = 1'b0; modeDword = 1'b0; bigSel = 1'b0; laneMask = 4'h0;
    opA = {128{1'b1}};
    repeat (3) @(negedge clk);
    // R9: reset state, even with the strobe high during reset
    inValid = 1'b1;
    @(negedge clk);
    check("R9 result", result, '0);
    check("R9 outValid", {127'b0, outValid}, 128'h0);
    rst = 1'b0; inValid = 1'b0;

    // Table walk: every operand against every mode/select/mask
    for (int k = 0; k < N_OPS; k++) begin
      for (int c = 0; c < 64; c++) begin
        logic dw = c[5];
        logic big = c[4];
        logic [3:0] m = c[3:0];
        string tag = dw ? (big ? "R4" : "R3") : (big ? "R2" : "R1");
        apply(OPS[k], dw, big, m);
        check(tag, result, model(OPS[k], dw, big, m));
        check("R7 outValid high", {127'b0, outValid}, 128'h1);
        held = result;
        @(negedge clk);
        check("R7 outValid low", {127'b0, outValid}, 128'h0);
        check("R8 hold", result, held);
      end
    end

    // R5: fixed values, lanes picked by mask bits from the top
    apply({4{32'h1}}, 1'b0, 1'b0, 4'b0101);
    check("R5 small", result, {32'h02004000, 32'h0000a000, 32'h02004000, 32'h0000a000});
    apply({4{32'h1}}, 1'b0, 1'b1, 4'b1001);
    check("R5 big", result, {32'h04200080, 32'h40080400, 32'h40080400, 32'h04200080});

    // R6: 64-bit lanes use mask bits 3 and 1 only
    apply({2{64'h1}}, 1'b1, 1'b0, 4'b0010);
    check("R6 pick", result, {64'h8100000000000000, 64'h0000200000000008});
    apply({2{64'h1}}, 1'b1, 1'b0, 4'b1101);
    check("R6 ignored bits", result, {64'h0000200000000008, 64'h8100000000000000});
    apply({2{64'h1}}, 1'b1, 1'b0, 4'b1000);
    check("R6 ignored bits cleared", result, {64'h0000200000000008, 64'h8100000000000000});

    // R10: zero and all-ones shapes
    apply('0, 1'b1, 1'b1, 4'b1111);
    check("R10 zero", result, '0);
    apply({128{1'b1}}, 1'b0, 1'b1, 4'b0110);
    check("R10 ones big", result, {128{1'b1}});
    apply({128{1'b1}}, 1'b0, 1'b0, 4'b0000);
    check("R1 ones small", result, {4{32'h1fffffff}});

    // R8: inputs change while the strobe is low
    held = result;
    @(negedge clk);
    opA = 128'h5; bigSel = 1'b1; laneMask = 4'hf;
    @(negedge clk);
    check("R8 no load", result, held);

    // R9: reset mid-run clears the register
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 mid reset", result, '0);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule